// File: doc/BRIEF.md
# Pipeline Stall Detection Unit

This block guards a five-stage integer pipeline that has no result forwarding. Each cycle it looks at the source register fields of the instruction sitting in decode and tests them against the destination registers of the two older instructions still in flight, in execute and in memory. A destination only counts when its instruction is valid, will write the register file, and does not name register zero. The register file writes in the first half of a cycle and reads in the second, so a producer that has reached write-back is no longer a hazard.

When a dependency is found, the unit freezes the program counter and the fetch/decode pipeline register, so the consumer stays in decode. In the same cycle it lets a copy of that held instruction move into execute with both its register-write and memory-write enables cleared, so the copy changes no state. Execute, memory and write-back keep advancing. The stall therefore repeats until the producer has left memory: at most two cycles for a back-to-back pair, one with one independent instruction between them, none with two.

Rs is always compared. Rt is compared only when the decoding instruction reads it as a source: the register-register group (opcode 0x00) and stores (opcode 0x2B). Loads, add-immediate and set-less-than-immediate use Rt as a destination, so their Rt field is ignored.

Top module: `stall_detect_unit`

## Requirements
- R1: With `idValid`=1, an Rs field equal to a live execute destination drives `pcHold` high in the same cycle.
- R2: With `idValid`=1, an Rs field equal to a live memory destination drives `pcHold` high in the same cycle.
- R3: The Rt field causes a stall only when `idOpcode` is 0x00 or 0x2B; for any other opcode an Rt match alone leaves `pcHold` at 0.
- R4: A destination register of 0 never causes a stall, even with its valid and register-write bits set.
- R5: An execute or memory entry whose valid bit or register-write bit is 0 never causes a stall.
- R6: With `idValid`=0 no stall is raised, whatever the other inputs are.
- R7: `pcHold`, `ifIdHold` and `bubble` are always equal; with all inputs at 0, all three are 0.
- R8: `exRegWriteNext` equals `idRegWrite` and `exMemWriteNext` equals `idMemWrite` when there is no stall; during a stall both are 0.
- R9: In a pipeline built around the unit, a consumer of Rs directly after its producer stalls 2 cycles, with one independent instruction between them 1 cycle, with two or three between them 0 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only for the embedded checks |
| rstN | input | 1 | Active-low reset, disables the embedded checks |
| idValid | input | 1 | Decode stage holds a real instruction |
| idOpcode | input | 6 | Opcode of the decoding instruction |
| idRs | input | REG_BITS | First source register field in decode |
| idRt | input | REG_BITS | Second register field in decode |
| idRegWrite | input | 1 | Register-write enable decoded for the instruction in decode |
| idMemWrite | input | 1 | Memory-write enable decoded for the instruction in decode |
| exValid | input | 1 | Execute stage holds a real instruction |
| exRegWrite | input | 1 | Execute instruction will write the register file |
| exDest | input | REG_BITS | Destination register of the execute instruction |
| memValid | input | 1 | Memory stage holds a real instruction |
| memRegWrite | input | 1 | Memory instruction will write the register file |
| memDest | input | REG_BITS | Destination register of the memory instruction |
| pcHold | output | 1 | Keep the program counter unchanged this cycle |
| ifIdHold | output | 1 | Keep the fetch/decode pipeline register unchanged this cycle |
| bubble | output | 1 | The instruction entering execute is a disarmed copy |
| exRegWriteNext | output | 1 | Register-write enable to load into the execute stage |
| exMemWriteNext | output | 1 | Memory-write enable to load into the execute stage |

## Verification
The unit is purely combinational, so any wrong comparison, qualifier or opcode decode shows at `pcHold` and the write-enable outputs in the very cycle the offending inputs are applied, with no latency to hide it. A missed match lets a consumer read a stale register, visible as a missing stall cycle in the pipeline sequence; a false match shows as an extra hold or a write enable cleared without cause. A near-exhaustive sweep over a narrowed register width compares every output against an arithmetic model, and a small pipeline model counts stall cycles for producer-consumer gaps of zero to three.

// File: rtl/stall_detect_pkg.sv
package stall_detect_pkg;

  // Opcodes whose Rt field is a source operand.
  localparam logic [5:0] OP_REG_REG = 6'h00;
  localparam logic [5:0] OP_STORE   = 6'h2B;

  // Number of older stages compared against decode (execute, memory).
  localparam int OLDER_STAGES = 2;
  localparam int STAGE_EX  = 0;
  localparam int STAGE_MEM = 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic holdFront;   // freeze PC and fetch/decode register
    logic killWrites;  // clear write enables of the copy entering execute
  } stallStrobes_t;

endpackage

// File: rtl/stall_detect_compare.sv
module stall_detect_compare
  import stall_detect_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0]                   idRs,
  input  logic [REG_BITS-1:0]                   idRt,
  input  logic                                  idRegWrite,
  input  logic                                  idMemWrite,
  input  logic [OLDER_STAGES-1:0]               olderValid,
  input  logic [OLDER_STAGES-1:0]               olderRegWrite,
  input  logic [OLDER_STAGES-1:0][REG_BITS-1:0] olderDest,
  input  stallStrobes_t                         strobes,
  output logic [OLDER_STAGES-1:0]               rsHit,
  output logic [OLDER_STAGES-1:0]               rtHit,
  output logic                                  exRegWriteNext,
  output logic                                  exMemWriteNext
);

  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  logic [OLDER_STAGES-1:0] destLive;

  for (genvar s = 0; s < OLDER_STAGES; s++) begin : g_stage
    always_comb begin
      destLive[s] = olderValid[s] && olderRegWrite[s] && (olderDest[s] != ZERO_REG);
      rsHit[s]    = destLive[s] && (idRs == olderDest[s]);
      rtHit[s]    = destLive[s] && (idRt == olderDest[s]);
    end
  end

  // The held copy travels on with its state-changing enables disarmed.
  always_comb begin
    exRegWriteNext = idRegWrite && !strobes.killWrites;
    exMemWriteNext = idMemWrite && !strobes.killWrites;
  end

endmodule

// File: rtl/stall_detect_ctrl.sv
module stall_detect_ctrl
  import stall_detect_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    idValid,
  input  logic [5:0]              idOpcode,
  input  logic [OLDER_STAGES-1:0] rsHit,
  input  logic [OLDER_STAGES-1:0] rtHit,
  output stallStrobes_t           strobes
);

  logic readsRt;
  logic hazard;

  always_comb begin
    readsRt = (idOpcode == OP_REG_REG) || (idOpcode == OP_STORE);
    hazard  = idValid && ((|rsHit) || (readsRt && (|rtHit)));
    strobes.holdFront  = hazard;
    strobes.killWrites = hazard;
  end

  AST_RT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (idOpcode != OP_REG_REG && idOpcode != OP_STORE && rsHit == '0) |-> !strobes.holdFront) // R3
    else $error("Rt field stalled an instruction that does not read it");

  AST_IDLE_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> !strobes.holdFront) // R6
    else $error("stall raised with empty decode stage");

endmodule

// File: rtl/stall_detect_unit.sv
module stall_detect_unit
  import stall_detect_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                idValid,
  input  logic [5:0]          idOpcode,
  input  logic [REG_BITS-1:0] idRs,
  input  logic [REG_BITS-1:0] idRt,
  input  logic                idRegWrite,
  input  logic                idMemWrite,
  input  logic                exValid,
  input  logic                exRegWrite,
  input  logic [REG_BITS-1:0] exDest,
  input  logic                memValid,
  input  logic                memRegWrite,
  input  logic [REG_BITS-1:0] memDest,
  output logic                pcHold,
  output logic                ifIdHold,
  output logic                bubble,
  output logic                exRegWriteNext,
  output logic                exMemWriteNext
);

  logic [OLDER_STAGES-1:0]               olderValid;
  logic [OLDER_STAGES-1:0]               olderRegWrite;
  logic [OLDER_STAGES-1:0][REG_BITS-1:0] olderDest;
  logic [OLDER_STAGES-1:0]               rsHit;
  logic [OLDER_STAGES-1:0]               rtHit;
  stallStrobes_t                         strobes;

  always_comb begin
    olderValid[STAGE_EX]     = exValid;
    olderRegWrite[STAGE_EX]  = exRegWrite;
    olderDest[STAGE_EX]      = exDest;
    olderValid[STAGE_MEM]    = memValid;
    olderRegWrite[STAGE_MEM] = memRegWrite;
    olderDest[STAGE_MEM]     = memDest;
  end

  stall_detect_compare #(.REG_BITS(REG_BITS)) u_compare (
    .idRs           (idRs),
    .idRt           (idRt),
    .idRegWrite     (idRegWrite),
    .idMemWrite     (idMemWrite),
    .olderValid     (olderValid),
    .olderRegWrite  (olderRegWrite),
    .olderDest      (olderDest),
    .strobes        (strobes),
    .rsHit          (rsHit),
    .rtHit          (rtHit),
    .exRegWriteNext (exRegWriteNext),
    .exMemWriteNext (exMemWriteNext)
  );

  stall_detect_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .idValid  (idValid),
    .idOpcode (idOpcode),
    .rsHit    (rsHit),
    .rtHit    (rtHit),
    .strobes  (strobes)
  );

  always_comb begin
    pcHold   = strobes.holdFront;
    ifIdHold = strobes.holdFront;
    bubble   = strobes.killWrites;
  end

  AST_HOLDS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (pcHold == ifIdHold) && (bubble == pcHold)) // R7
    else $error("hold and bubble strobes disagree");

  AST_BUBBLE_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    bubble |-> (!exRegWriteNext && !exMemWriteNext)) // R8
    else $error("bubble carries a write enable");

  AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> ((exValid && exRegWrite && exDest != '0) ||
                (memValid && memRegWrite && memDest != '0))) // R5
    else $error("stall without a live older destination");

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !pcHold |-> (exRegWriteNext == idRegWrite && exMemWriteNext == idMemWrite)) // R8
    else $error("write enables altered without a stall");

endmodule

// File: tb/stall_detect_unit_test.sv
module stall_detect_unit_test;

  localparam int RB = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          idValid = 1'b0;
  logic [5:0]    idOpcode = '0;
  logic [RB-1:0] idRs = '0, idRt = '0;
  logic          idRegWrite = 1'b0, idMemWrite = 1'b0;
  logic          exValid = 1'b0, exRegWrite = 1'b0;
  logic [RB-1:0] exDest = '0;
  logic          memValid = 1'b0, memRegWrite = 1'b0;
  logic [RB-1:0] memDest = '0;
  logic          pcHold, ifIdHold, bubble, exRegWriteNext, exMemWriteNext;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stall_detect_unit #(.REG_BITS(RB)) uut (
    .clk(clk), .rstN(rstN), .idValid(idValid), .idOpcode(idOpcode),
    .idRs(idRs), .idRt(idRt), .idRegWrite(idRegWrite), .idMemWrite(idMemWrite),
    .exValid(exValid), .exRegWrite(exRegWrite), .exDest(exDest),
    .memValid(memValid), .memRegWrite(memRegWrite), .memDest(memDest),
    .pcHold(pcHold), .ifIdHold(ifIdHold), .bubble(bubble),
    .exRegWriteNext(exRegWriteNext), .exMemWriteNext(exMemWriteNext)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Drive after the falling edge, sample 1 ns later.
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic setAll(input bit iv, input logic [5:0] op, input int rs, input int rt,
                        input bit irw, input bit imw,
                        input bit ev, input bit erw, input int ed,
                        input bit mv, input bit mrw, input int md);
    idValid = iv; idOpcode = op; idRs = RB'(rs); idRt = RB'(rt);
    idRegWrite = irw; idMemWrite = imw;
    exValid = ev; exRegWrite = erw; exDest = RB'(ed);
    memValid = mv; memRegWrite = mrw; memDest = RB'(md);
  endtask

  function automatic bit modelStall();
    bit liveEx, liveMem, readsRt;
    liveEx  = exValid && exRegWrite && (exDest != 0);
    liveMem = memValid && memRegWrite && (memDest != 0);
    readsRt = (idOpcode == 6'h00) || (idOpcode == 6'h2B);
    return idValid && ((liveEx && (idRs == exDest || (readsRt && idRt == exDest))) ||
                       (liveMem && (idRs == memDest || (readsRt && idRt == memDest))));
  endfunction

  // Small pipeline model around the unit: producer writes r1, gap of
  // instructions writing r0, consumer reads r1 through Rs.
  task automatic runGap(input int gap, input int expStalls);
    int pc = 0;
    int stalls = 0;
    int total = gap + 2;
    bit eV = 0, eW = 0, mV = 0, mW = 0;
    int eD = 0, mD = 0;
    bit s;
    for (int cyc = 0; cyc < 20 && pc < total; cyc++) begin
      if (pc == 0)               setAll(1, 6'h00, 2, 3, 1, 0, eV, eW, eD, mV, mW, mD);
      else if (pc == total - 1)  setAll(1, 6'h00, 1, 3, 1, 0, eV, eW, eD, mV, mW, mD);
      else                       setAll(1, 6'h00, 0, 0, 1, 0, eV, eW, eD, mV, mW, mD);
      settle();
      s = pcHold;
      if (s) stalls++;
      mV = eV; mW = eW; mD = eD;
      eV = 1'b1; eW = exRegWriteNext;
      eD = (pc == 0) ? 1 : ((pc == total - 1) ? 2 : 0);
      if (!s) pc++;
    end
    check($sformatf("R9 gap=%0d stall cycles", gap), stalls, expStalls);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // Reset state with all inputs zero.
    settle();
    check("R7 reset pcHold", pcHold, 0);
    check("R7 reset ifIdHold", ifIdHold, 0);
    check("R7 reset bubble", bubble, 0);
    rstN = 1'b1;

    // Directed cases.
    setAll(1, 6'h23, 2, 0, 1, 0, 1, 1, 2, 0, 0, 0); settle();
    check("R1 rs vs execute", pcHold, 1);
    setAll(1, 6'h23, 3, 0, 1, 0, 0, 0, 0, 1, 1, 3); settle();
    check("R2 rs vs memory", pcHold, 1);
    setAll(1, 6'h23, 0, 2, 1, 0, 1, 1, 2, 1, 1, 2); settle();
    check("R3 load rt ignored", pcHold, 0);
    setAll(1, 6'h2B, 0, 2, 0, 1, 1, 1, 2, 0, 0, 0); settle();
    check("R3 store rt compared", pcHold, 1);
    check("R8 store bubble memwrite", exMemWriteNext, 0);
    setAll(1, 6'h00, 0, 0, 1, 0, 1, 1, 0, 1, 1, 0); settle();
    check("R4 zero destination", pcHold, 0);
    setAll(1, 6'h00, 1, 2, 1, 0, 0, 1, 1, 1, 0, 2); settle();
    check("R5 invalid or non-writing older", pcHold, 0);
    setAll(0, 6'h00, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1); settle();
    check("R6 empty decode", pcHold, 0);
    check("R8 pass-through regwrite", exRegWriteNext, 1);
    check("R8 pass-through memwrite", exMemWriteNext, 1);

    // Near-exhaustive sweep.
    for (int o = 0; o < 4; o++) begin
      logic [5:0] op;
      op = (o == 0) ? 6'h00 : (o == 1) ? 6'h2B : (o == 2) ? 6'h23 : 6'h0A;
      for (int v = 0; v < (1 << (4 * RB + 5)); v++) begin
        bit exp;
        setAll(v[0], op, (v >> 5) & 3, (v >> 7) & 3, v[0] ^ v[3], v[1] ^ v[4],
               v[1], v[2], (v >> 9) & 3, v[3], v[4], (v >> 11) & 3);
        settle();
        exp = modelStall();
        check(idValid ? "R1 sweep stall" : "R6 sweep stall", pcHold, exp);
        if (ifIdHold != pcHold || bubble != pcHold)
          check("R7 sweep strobes agree", {ifIdHold, bubble}, {pcHold, pcHold});
        if (exRegWriteNext != (idRegWrite && !exp) || exMemWriteNext != (idMemWrite && !exp))
          check("R8 sweep write enables", {exRegWriteNext, exMemWriteNext},
                {idRegWrite && !exp, idMemWrite && !exp});
      end
    end

    // Producer-consumer spacing.
    runGap(0, 2);
    runGap(1, 1);
    runGap(2, 0);
    runGap(3, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule